// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the address-phase front end of an I2C target. It watches the bus through a two-flop synchronizer on each line. It recognizes START, repeated START and STOP. After a START it shifts in the first byte, which holds seven address bits followed by the direction bit. The byte then goes one of two ways.

In autonomous mode the block compares the address with its programmed own address. On a match it pulls SDA low through the ninth clock. On a mismatch it leaves SDA released and goes back to idle, and it ignores the bus until the next START. In handoff mode it holds SCL low after the eighth bit, raises a status flag and makes the byte readable. It then waits for a release strobe that carries an ACK or NAK choice.

After an acknowledged address the block reports that it is addressed, together with the latched direction bit. The following data phase uses these outputs. A small register port holds the global enable, the mode select and the own address, and reads back the captured byte.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While the global enable (control bit 0) is clear, the block never pulls SDA or SCL low, never raises the flag and never reports addressed. This holds even with autonomous compare (control bit 1) set.
- R2: With enable and autonomous compare both set, an address whose seven bits equal the own address is acknowledged: SDA is low while SCL is high in the ninth clock. After the ninth falling edge, `addressed` is 1 and `rw_dir` equals the eighth bit received.
- R3: With autonomous compare set, a mismatching address leaves SDA released in the ninth clock. The block then stays idle, and a later byte carrying the own address with no new START is not acknowledged.
- R4: With autonomous compare clear, the block does the following after the eighth bit. It raises `addr_flag`. It keeps SCL low even when the controller releases it. It presents the received byte at register select 2, with the address in bits 7:1 and the direction in bit 0.
- R5: A `fw_rel` pulse with `fw_ack`=1 clears the flag and releases SCL. It then acknowledges in the ninth clock and leads to `addressed`=1, with `rw_dir` latched.
- R6: A `fw_rel` pulse with `fw_ack`=0 clears the flag and releases SCL. It leaves SDA released in the ninth clock and returns the block to idle, with `addressed`=0.
- R7: The register port works as follows. Select 0 is control: bit 0 is enable and bit 1 is autonomous compare. Select 1 is the 7-bit own address in bits 6:0. Select 3 reads zero. Every register resets to zero. Reserved bits read as zero whatever is written to them.
- R8: In handoff mode the own address has no effect: the flag and the stall occur for any received address.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle and clears `addressed`.
- R10: A repeated START clears `addressed` and restarts the address phase. A matching address that follows is acknowledged again, with its own direction bit.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for the selected register |
| scl_i | input | 1 | SCL level sensed on the bus |
| sda_i | input | 1 | SDA level sensed on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (open-drain stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| addr_flag | output | 1 | Address received, awaiting the firmware decision |
| fw_rel | input | 1 | One-cycle release strobe from firmware |
| fw_ack | input | 1 | Decision sampled with fw_rel: 1 acknowledges, 0 rejects |
| addressed | output | 1 | Address acknowledged; data phase may proceed |
| rw_dir | output | 1 | Direction bit of the acknowledged address |

## Verification
A wrong bit count or a corrupted shift register appears on the bus within the same byte. The acknowledge then lands on the wrong clock, or the byte read back at select 2 differs from the byte sent, and either is visible before the ninth clock ends. A state that fails to leave the acknowledge or stall phases shows up as SDA or SCL held low past the point where the controller expects release. A wrong decision state shows up as `addressed` disagreeing with the expected ACK one half-period after the ninth falling edge. Randomized addresses, own addresses, modes and firmware choices exercise the match and decision paths against a reference computed from the requirements.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_DECIDE,
    ST_STALL,
    ST_RELEASE,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_SELECTED
  } am_state_t;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_OWN  = 2'd1;
  localparam logic [1:0] SEL_RXB  = 2'd2;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync
  import i2c_am_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] syn;
  logic [LINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[i]};
    end
    assign syn[i] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= '1;
    else        prv <= syn;
  end

  always_comb begin
    ev.scl      = syn[0];
    ev.sda      = syn[1];
    ev.scl_rise = syn[0] & ~prv[0];
    ev.scl_fall = ~syn[0] & prv[0];
    ev.start    = syn[0] & prv[0] & ~syn[1] & prv[1];
    ev.stop     = syn[0] & prv[0] & syn[1] & ~prv[1];
  end

endmodule

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W:0]   rx_byte,
  output logic              en,
  output logic              hw_cmp,
  output logic [ADDR_W-1:0] own_addr
);

  logic              en_q, hw_q;
  logic [ADDR_W-1:0] own_q;
  logic              ctrl_we, own_we;

  assign ctrl_we = cfg_wr && (cfg_sel == SEL_CTRL);
  assign own_we  = cfg_wr && (cfg_sel == SEL_OWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      hw_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q <= cfg_wdata[0];
      hw_q <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= '0;
    else if (own_we) own_q <= cfg_wdata[ADDR_W-1:0];
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_CTRL: cfg_rdata[1:0] = {hw_q, en_q};
      SEL_OWN:  cfg_rdata[ADDR_W-1:0] = own_q;
      SEL_RXB:  cfg_rdata[ADDR_W:0] = rx_byte;
      default:  cfg_rdata = '0;
    endcase
  end

  assign en       = en_q;
  assign hw_cmp   = hw_q;
  assign own_addr = own_q;

  AST_OWN_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == SEL_OWN) |-> (cfg_rdata[7] == 1'b0)); // R7
  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (en == $past(cfg_wdata[0]) && hw_cmp == $past(cfg_wdata[1]))); // R7

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              en,
  input  logic              hw_cmp,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              fw_rel,
  input  logic              fw_ack,
  output logic              sda_pull,
  output logic              scl_pull,
  output logic              addr_flag,
  output logic [ADDR_W:0]   rx_byte,
  output logic              addressed,
  output logic              rw_dir
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  am_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic              flag_q, flag_d;
  logic              sel_q, sel_d;
  logic              rw_q, rw_d;
  logic              hit;

  assign hit = (sh_q[BYTE_W-1:1] == own_addr);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rxb_d  = rxb_q;
    flag_d = flag_q;
    sel_d  = sel_q;
    rw_d   = rw_q;
    if (!en) begin
      st_d   = ST_IDLE;
      flag_d = 1'b0;
      sel_d  = 1'b0;
    end else if (ev.stop) begin
      st_d   = ST_IDLE;
      flag_d = 1'b0;
      sel_d  = 1'b0;
    end else if (ev.start) begin
      st_d   = ST_SHIFT;
      cnt_d  = '0;
      flag_d = 1'b0;
      sel_d  = 1'b0;
    end else begin
      case (st_q)
        ST_SHIFT: begin
          if (ev.scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], ev.sda};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) st_d = ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (ev.scl_fall) begin
            if (hw_cmp) begin
              if (hit) begin
                st_d = ST_ACK_LO;
                rw_d = sh_q[0];
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              st_d   = ST_STALL;
              flag_d = 1'b1;
              rxb_d  = sh_q;
            end
          end
        end
        ST_STALL: begin
          if (fw_rel) begin
            flag_d = 1'b0;
            if (fw_ack) begin
              st_d = ST_RELEASE;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_RELEASE: st_d = ST_ACK_LO;
        ST_ACK_LO:  if (ev.scl_rise) st_d = ST_ACK_HI;
        ST_ACK_HI: begin
          if (ev.scl_fall) begin
            st_d  = ST_SELECTED;
            sel_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rxb_q  <= '0;
      flag_q <= 1'b0;
      sel_q  <= 1'b0;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rxb_q  <= rxb_d;
      flag_q <= flag_d;
      sel_q  <= sel_d;
      rw_q   <= rw_d;
    end
  end

  assign sda_pull  = (st_q == ST_RELEASE) || (st_q == ST_ACK_LO) || (st_q == ST_ACK_HI);
  assign scl_pull  = (st_q == ST_STALL) || (st_q == ST_RELEASE);
  assign addr_flag = flag_q;
  assign rx_byte   = rxb_q;
  assign addressed = sel_q;
  assign rw_dir    = rw_q;

  AST_OFF_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_pull && !scl_pull && !addr_flag)); // R1
  AST_ACK_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && hw_cmp) |-> (sh_q[BYTE_W-1:1] == own_addr)); // R2
  AST_FLAG_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_flag |-> scl_pull); // R4
  AST_REL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_flag && fw_rel && en) |=> !addr_flag); // R5
  AST_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stop |=> !addressed); // R9
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_pull)) |-> !ev.scl); // R11

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       addr_flag,
  input  logic       fw_rel,
  input  logic       fw_ack,
  output logic       addressed,
  output logic       rw_dir
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  bus_ev_t           ev;
  logic              en, hw_cmp;
  logic [ADDR_W-1:0] own_addr;
  logic [ADDR_W:0]   rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  i2c_am_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  i2c_am_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rx_byte   (rx_byte),
    .en        (en),
    .hw_cmp    (hw_cmp),
    .own_addr  (own_addr)
  );

  i2c_am_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (ev),
    .en        (en),
    .hw_cmp    (hw_cmp),
    .own_addr  (own_addr),
    .fw_rel    (fw_rel),
    .fw_ack    (fw_ack),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull),
    .addr_flag (addr_flag),
    .rx_byte   (rx_byte),
    .addressed (addressed),
    .rw_dir    (rw_dir)
  );

endmodule

// File: tb/i2c_addr_matcher_tb.sv
module i2c_addr_matcher_tb;

  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       scl_pull, sda_pull, addr_flag, addressed, rw_dir;
  logic       fw_rel, fw_ack;
  logic       m_scl, m_sda;
  logic       scl_bus, sda_bus;

  int n_run = 0;
  int n_fail = 0;
  int sda_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_bus = m_scl & ~scl_pull;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_addr_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .scl_i(scl_bus),
    .sda_i(sda_bus), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .addr_flag(addr_flag), .fw_rel(fw_rel), .fw_ack(fw_ack),
    .addressed(addressed), .rw_dir(rw_dir)
  );

  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull && scl_bus) sda_bad++;
    prev_pull <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ack(input bit hw, input bit [6:0] a,
                                 input bit [6:0] own, input bit fwa);
    return hw ? (a == own) : fwa;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    wait_cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, output logic [7:0] d);
    cfg_sel = s;
    #1;
    d = cfg_rdata;
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wait_cyc(H);
    m_scl = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wait_cyc(H);
    m_scl = 1'b1; wait_cyc(H);
    m_sda = 1'b0; wait_cyc(H);
    m_scl = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_cyc(H);
    m_scl = 1'b1; wait_cyc(H);
    m_sda = 1'b1; wait_cyc(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_cyc(H);
    m_scl = 1'b1;
    while (!scl_bus) wait_cyc(1);
    wait_cyc(H);
    m_scl = 1'b0; wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic ninth(output bit acked);
    m_sda = 1'b1;
    if (!m_scl) begin
      wait_cyc(H);
      m_scl = 1'b1;
    end
    while (!scl_bus) wait_cyc(1);
    wait_cyc(H / 2);
    acked = !sda_bus;
    wait_cyc(H / 2);
    m_scl = 1'b0; wait_cyc(H);
  endtask

  task automatic fw_stage(input logic [7:0] byte_sent, input bit fwa,
                          input string req);
    logic [7:0] rb;
    wait_cyc(H);
    check(addr_flag === 1'b1, req, "flag after address", addr_flag, 1);
    cfg_read(2'd2, rb);
    check(rb === byte_sent, req, "captured byte", rb, byte_sent);
    m_sda = 1'b1; wait_cyc(2);
    m_scl = 1'b1; wait_cyc(6);
    check(scl_bus === 1'b0, req, "SCL stretched", scl_bus, 0);
    fw_ack = fwa; fw_rel = 1'b1;
    wait_cyc(1);
    fw_rel = 1'b0;
    wait_cyc(1);
    check(addr_flag === 1'b0, fwa ? "R5" : "R6", "flag cleared", addr_flag, 0);
  endtask

  task automatic addr_phase(input bit [6:0] a, input bit rw, input bit hw,
                            input bit fwa, input string req, output bit acked);
    send_byte({a, rw});
    if (!hw) fw_stage({a, rw}, fwa, req);
    ninth(acked);
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit ak;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    fw_rel = 1'b0; fw_ack = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    void'($urandom(32'd20240611));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R7 reset state and register port
    check(!scl_pull && !sda_pull && !addr_flag && !addressed, "R7", "reset outputs",
          {scl_pull, sda_pull, addr_flag, addressed}, 0);
    cfg_read(2'd0, rd); check(rd === 8'h00, "R7", "ctrl reset", rd, 0);
    cfg_read(2'd1, rd); check(rd === 8'h00, "R7", "own reset", rd, 0);
    cfg_write(2'd1, 8'hFF); cfg_read(2'd1, rd);
    check(rd === 8'h7F, "R7", "own reserved bit", rd, 8'h7F);
    cfg_write(2'd0, 8'hFF); cfg_read(2'd0, rd);
    check(rd === 8'h03, "R7", "ctrl reserved bits", rd, 8'h03);
    cfg_write(2'd3, 8'hFF); cfg_read(2'd3, rd);
    check(rd === 8'h00, "R7", "unused select", rd, 0);

    // R1 disabled with autonomous compare set
    cfg_write(2'd0, 8'h02); cfg_write(2'd1, 8'h55);
    bus_start(); send_byte({7'h55, 1'b0}); ninth(ak);
    check(ak == 1'b0, "R1", "ack while disabled", ak, 0);
    check(addressed === 1'b0 && addr_flag === 1'b0, "R1", "state while disabled",
          {addressed, addr_flag}, 0);
    bus_stop();

    // R2 match, then R10 repeated start, then R9 stop
    cfg_write(2'd0, 8'h03);
    bus_start(); addr_phase(7'h55, 1'b1, 1'b1, 1'b0, "R2", ak);
    check(ak == 1'b1, "R2", "ack on match", ak, 1);
    check(addressed === 1'b1 && rw_dir === 1'b1, "R2", "addressed/rw",
          {addressed, rw_dir}, 3);
    bus_rstart();
    check(addressed === 1'b0, "R10", "cleared by repeated start", addressed, 0);
    addr_phase(7'h55, 1'b0, 1'b1, 1'b0, "R10", ak);
    check(ak == 1'b1 && addressed === 1'b1 && rw_dir === 1'b0, "R10",
          "re-ack with new direction", {ak, addressed, rw_dir}, 6);
    bus_stop();
    check(addressed === 1'b0, "R9", "stop deselects", addressed, 0);

    // R3 mismatch then own address without START
    bus_start(); addr_phase(7'h2A, 1'b0, 1'b1, 1'b0, "R3", ak);
    check(ak == 1'b0, "R3", "nak on mismatch", ak, 0);
    send_byte({7'h55, 1'b0}); ninth(ak);
    check(ak == 1'b0 && addressed === 1'b0, "R3", "idle until START",
          {ak, addressed}, 0);
    bus_stop();

    // R4 R5 R8 handoff mode with a non-matching address
    cfg_write(2'd0, 8'h01);
    bus_start(); addr_phase(7'h13, 1'b1, 1'b0, 1'b1, "R4", ak);
    check(ak == 1'b1, "R8", "own address ignored, fw ack", ak, 1);
    check(addressed === 1'b1 && rw_dir === 1'b1, "R5", "addressed after fw ack",
          {addressed, rw_dir}, 3);
    bus_stop();

    // R6 firmware rejects a matching address
    bus_start(); addr_phase(7'h55, 1'b0, 1'b0, 1'b0, "R6", ak);
    check(ak == 1'b0 && addressed === 1'b0, "R6", "fw nak", {ak, addressed}, 0);
    bus_stop();

    // random mix
    for (int it = 0; it < 40; it++) begin
      bit hw = 1'($urandom_range(0, 1));
      bit [6:0] own = 7'($urandom_range(0, 127));
      bit [6:0] a = ($urandom_range(0, 2) == 0) ? own : 7'($urandom_range(0, 127));
      bit rw = 1'($urandom_range(0, 1));
      bit fwa = 1'($urandom_range(0, 1));
      bit e;
      cfg_write(2'd0, {6'd0, hw, 1'b1});
      cfg_write(2'd1, {1'b0, own});
      e = exp_ack(hw, a, own, fwa);
      bus_start(); addr_phase(a, rw, hw, fwa, hw ? "R2" : "R4", ak);
      check(ak == e, hw ? "R2" : "R5", "random ack", ak, e);
      check(addressed === e, hw ? "R3" : "R6", "random addressed", addressed, e);
      if (e) check(rw_dir === rw, "R2", "random direction", rw_dir, rw);
      bus_stop();
      check(addressed === 1'b0, "R9", "random stop", addressed, 0);
    end

    check(sda_bad == 0, "R11", "SDA changed with SCL high", sda_bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule